// File: doc/BRIEF.md
# Serial Transmit Channel with Byte Queue and Line Break

This block is the sending half of an asynchronous serial link. A host writes bytes into a 16-entry first-in first-out queue through a simple push port. Whenever the serialiser is idle and the queue holds a byte, the serialiser takes the oldest byte. It sends a low start bit, then 5 to 8 data bits with the least significant bit first. An optional parity bit follows, then a high stop period of programmable length. When nothing is being sent, the line rests high.

Bit timing comes from an external oversampling strobe. Each bit lasts 16 strobes, so the divisor that sets the rate is outside this block. A break control pulls the line low for as long as it is held. The host or a DMA engine paces its writes with a ready output that is high while the queue has room. Two separate flags report whether the queue is empty and whether the serialiser has finished its last stop period.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset the line output is high, the ready output is high, and both the queue-empty and shifter-empty flags are high.
- R2: Each character starts with one low bit. The data bits follow least significant bit first. The count of data bits is set by `fmt_len`: code 0 sends 5 bits, 1 sends 6, 2 sends 7 and 3 sends 8.
- R3: When `fmt_par_en` is 1, one parity bit follows the data bits. With `fmt_par_odd` at 0, the count of ones in the data bits plus the parity bit is even. With `fmt_par_odd` at 1, that count is odd. When `fmt_par_en` is 0, no parity bit is sent.
- R4: The stop period is high. With `fmt_stop_long` at 0 it lasts 16 strobes. With `fmt_stop_long` at 1 it lasts 24 strobes for 5-bit characters and 32 strobes for 6- to 8-bit characters.
- R5: The start, data and parity bits each last 16 `baud_tick` strobes. While no strobe arrives, a character in progress does not advance.
- R6: The queue holds up to 16 bytes and sends them in the order they were pushed.
- R7: `tx_ready` is high while the queue holds fewer than 16 bytes and low while it holds 16.
- R8: A push while the queue holds 16 bytes is dropped. The stored bytes and their order are unchanged.
- R9: `fifo_empty` goes high in the cycle the last queued byte moves into the serialiser. `shifter_empty` stays low until the final stop period of that byte has completed.
- R10: While `line_break` is high, `txd` is low, including in the middle of a character. The serialiser keeps its timing underneath, so a character sent during a break still takes its normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Write one byte into the queue this cycle |
| push_data | input | 8 | Byte to write |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit period |
| fmt_len | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| fmt_par_en | input | 1 | Send a parity bit |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| fmt_stop_long | input | 1 | Longer stop period (1.5 bits for 5-bit characters, 2 bits otherwise) |
| line_break | input | 1 | Hold the line low |
| txd | output | 1 | Serial line output |
| tx_ready | output | 1 | Queue has free space |
| fifo_empty | output | 1 | Queue holds no bytes |
| shifter_empty | output | 1 | Serialiser idle, last stop period completed |

## Verification
A pushed byte is written at the next clock edge. If the serialiser is idle, the byte is loaded one edge later, and `txd` falls in that same cycle. Every later bit boundary depends on strobe arrival, not on the clock. The bench therefore strobes every second cycle and finds the falling start edge. It then samples each bit 16 cycles into its 32-cycle span, which is well clear of the one-cycle strobe phase uncertainty. The full character length is measured from the detected start to the rise of `shifter_empty`, with a two-cycle window. Queue flags and `tx_ready` are read a few cycles after the last push, once the write and load edges have passed.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial transmit channel.
// Assumes characters are at most 8 bits wide.
package uart_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       stop_long;
    } tx_fmt_t;

    // Number of data bits for a length code (0..3 -> 5..8).
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // Mask keeping only the data bits that a length code sends.
    function automatic logic [DATA_W-1:0] data_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
// Byte queue for the transmit channel: first in, first out, with a
// combinational read port. A write while full is dropped; reads are
// only issued by the serialiser when the queue is not empty.
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST_IDX  = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT  = CNTW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CNTW-1:0]  count;
    logic             do_wr;
    logic             do_rd;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Store an accepted byte; storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and occupancy on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // A dropped push leaves the queue full and its occupancy unchanged.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));

    // The serialiser never pops an empty queue.
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    // Occupancy never exceeds the depth.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/uart_tx_shifter.sv
// Character serialiser. It loads one byte from the queue when idle and
// sends start, data (LSB first), optional parity and stop. Each phase is
// timed in oversampling strobes. The format is captured at load, so
// changes during a character take effect on the next one.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  tx_fmt_t           fmt,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    output logic              line_bit,
    output logic              busy
);
    localparam int CW = $clog2(2 * TICKS_PER_BIT);
    localparam logic [CW-1:0] LIM_BIT   = CW'(TICKS_PER_BIT - 1);
    localparam logic [CW-1:0] LIM_HALF3 = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [CW-1:0] LIM_TWO   = CW'(2 * TICKS_PER_BIT - 1);

    tx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     limit;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        bit_idx;
    tx_fmt_t           fmt_q;
    logic              par_q;
    logic              bit_done;
    logic [DATA_W-1:0] masked;

    assign masked   = src_data & data_mask(fmt.len_code);
    assign src_pop  = (state == ST_IDLE) && src_valid;
    assign busy     = (state != ST_IDLE);
    assign bit_done = baud_tick && (cnt == limit);

    // Select the strobe count that ends the current phase.
    always_comb begin
        limit = LIM_BIT;
        if (state == ST_STOP && fmt_q.stop_long) begin
            limit = (fmt_q.len_code == 2'd0) ? LIM_HALF3 : LIM_TWO;
        end
    end

    // Drive the line level for the current phase.
    always_comb begin
        case (state)
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    // Phase sequencing, strobe counting and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            fmt_q   <= '0;
            par_q   <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (src_valid) begin
                shreg   <= masked;
                fmt_q   <= fmt;
                par_q   <= (^masked) ^ fmt.par_odd;
                cnt     <= '0;
                bit_idx <= '0;
                state   <= ST_START;
            end
        end else if (baud_tick) begin
            if (cnt == limit) begin
                cnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg   <= shreg >> 1;
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == data_bits(fmt_q.len_code) - 4'd1) begin
                            state <= fmt_q.par_en ? ST_PARITY : ST_STOP;
                        end
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Without a strobe a character in progress holds its phase and count.
    p_tick_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !baud_tick) |=> ($stable(state) && $stable(cnt)));

    // The data phase never runs past the configured bit count.
    p_data_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bit_done) |-> (bit_idx < data_bits(fmt_q.len_code)));

    // A finished stop period always returns to idle.
    p_stop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bit_done) |=> (state == ST_IDLE));

endmodule

// File: rtl/serial_tx_engine.sv
// Top of the serial transmit channel: byte queue, serialiser and the
// break override on the line. Assumes baud_tick is a one-cycle strobe
// at 16 times the bit rate and that the format is stable between characters.
module serial_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       baud_tick,
    input  logic [1:0] fmt_len,
    input  logic       fmt_par_en,
    input  logic       fmt_par_odd,
    input  logic       fmt_stop_long,
    input  logic       line_break,
    output logic       txd,
    output logic       tx_ready,
    output logic       fifo_empty,
    output logic       shifter_empty
);
    tx_fmt_t           fmt;
    logic [DATA_W-1:0] q_data;
    logic              q_full;
    logic              q_pop;
    logic              line_bit;
    logic              sh_busy;

    assign fmt = '{len_code: fmt_len, par_en: fmt_par_en,
                   par_odd: fmt_par_odd, stop_long: fmt_stop_long};

    uart_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_valid),
        .wr_data (push_data),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .empty   (fifo_empty),
        .full    (q_full)
    );

    uart_tx_shifter #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .fmt       (fmt),
        .src_valid (!fifo_empty),
        .src_data  (q_data),
        .src_pop   (q_pop),
        .line_bit  (line_bit),
        .busy      (sh_busy)
    );

    // Break overrides the serialiser's line level.
    assign txd           = line_bit && !line_break;
    assign tx_ready      = !q_full;
    assign shifter_empty = !sh_busy;

    // The queue only drains into a serialiser that becomes busy.
    p_empty_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_empty) |-> !shifter_empty);

endmodule

// File: tb/tb_serial_tx_engine.sv
`timescale 1ns/1ps
module tb_serial_tx_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       tick_en = 1'b0;
    logic       ph = 1'b0;
    logic       baud_tick;
    logic [1:0] fmt_len = 2'd3;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_odd = 1'b0;
    logic       fmt_stop_long = 1'b0;
    logic       line_break = 1'b0;
    logic       txd, tx_ready, fifo_empty, shifter_empty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        ph     <= ~ph;
        cycles <= cycles + 1;
    end
    assign baud_tick = tick_en && ph;

    serial_tx_engine dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .baud_tick(baud_tick), .fmt_len(fmt_len), .fmt_par_en(fmt_par_en),
        .fmt_par_odd(fmt_par_odd), .fmt_stop_long(fmt_stop_long),
        .line_break(line_break), .txd(txd), .tx_ready(tx_ready),
        .fifo_empty(fifo_empty), .shifter_empty(shifter_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = b;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // Receive one character and compare it with the format rules.
    task automatic recv(input logic [7:0] b, input logic [1:0] lc, input bit pe,
                        input bit po, input bit sl);
        int nd;
        int n;
        int st;
        int expc;
        logic [7:0] m;
        logic par;
        nd  = 5 + int'(lc);
        m   = b & (8'hFF >> (2'd3 - lc));
        par = (^m) ^ po;
        st  = !sl ? 16 : ((lc == 2'd0) ? 24 : 32);
        n = 0;
        while (txd !== 1'b0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 4000, "R2 start seen", n, 0);
        repeat (16) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit low", int'(txd), 0);
        for (int i = 0; i < nd; i++) begin
            repeat (32) @(negedge clk);
            chk(txd == m[i], "R2 data bit", int'(txd), int'(m[i]));
        end
        if (pe) begin
            repeat (32) @(negedge clk);
            chk(txd == par, "R3 parity bit", int'(txd), int'(par));
        end
        repeat (32) @(negedge clk);
        chk(txd == 1'b1, "R4 stop level", int'(txd), 1);
        n = 16 + 32 * (nd + int'(pe) + 1);
        while (!shifter_empty && n < 5000) begin
            @(negedge clk);
            n++;
        end
        expc = 2 * (16 * (1 + nd + int'(pe)) + st);
        chk(n >= expc - 2 && n <= expc + 2, "R4 R5 character length", n, expc);
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        chk(1'b0, "watchdog", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        chk(fifo_empty == 1'b1, "R1 fifo empty", int'(fifo_empty), 1);
        chk(shifter_empty == 1'b1, "R1 shifter empty", int'(shifter_empty), 1);

        // R2 R3 R4: sweep every length, parity mode and stop setting
        tick_en = 1'b1;
        for (int lc = 0; lc < 4; lc++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    for (int k = 0; k < 2; k++) begin
                        @(negedge clk);
                        fmt_len       = 2'(lc);
                        fmt_par_en    = (pm != 0);
                        fmt_par_odd   = (pm == 2);
                        fmt_stop_long = sl[0];
                        b = 8'hA5 ^ 8'((lc * 6 + pm * 2 + sl) * 37);
                        if (k == 1) b = ~b;
                        push(b);
                        recv(b, 2'(lc), pm != 0, pm == 2, sl[0]);
                    end
                end
            end
        end

        // R5 R6 R7 R8 R9: fill the queue with strobes stopped
        @(negedge clk);
        fmt_len = 2'd3; fmt_par_en = 1'b0; fmt_par_odd = 1'b0; fmt_stop_long = 1'b0;
        tick_en = 1'b0;
        push(8'h11);
        repeat (3) @(negedge clk);
        chk(fifo_empty == 1'b1, "R9 queue empty after load", int'(fifo_empty), 1);
        chk(shifter_empty == 1'b0, "R9 shifter busy", int'(shifter_empty), 0);
        repeat (100) @(negedge clk);
        chk(txd == 1'b0, "R5 start held without strobes", int'(txd), 0);
        for (int k = 0; k < 15; k++) push(8'(k * 29 + 7));
        @(negedge clk);
        chk(tx_ready == 1'b1, "R7 ready with 15 held", int'(tx_ready), 1);
        push(8'(15 * 29 + 7));
        @(negedge clk);
        chk(tx_ready == 1'b0, "R7 not ready when full", int'(tx_ready), 0);
        push(8'hEE);
        @(negedge clk);
        chk(tx_ready == 1'b0, "R8 still full after dropped push", int'(tx_ready), 0);
        chk(fifo_empty == 1'b0, "R6 queue holds data", int'(fifo_empty), 0);
        tick_en = 1'b1;
        recv(8'h11, 2'd3, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(tx_ready == 1'b1, "R7 ready after one drained", int'(tx_ready), 1);
        for (int k = 0; k < 16; k++) begin
            if (k == 15) begin
                n = 0;
                while (txd !== 1'b0 && n < 4000) begin
                    @(negedge clk);
                    n++;
                end
                chk(fifo_empty == 1'b1, "R9 empty when last byte loads", int'(fifo_empty), 1);
                chk(shifter_empty == 1'b0, "R9 shifter busy on last byte", int'(shifter_empty), 0);
            end
            recv(8'(k * 29 + 7), 2'd3, 1'b0, 1'b0, 1'b0);
        end
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R8 dropped byte never sent", int'(txd), 1);
        chk(fifo_empty == 1'b1 && shifter_empty == 1'b1, "R9 both empty at end",
            int'(fifo_empty && shifter_empty), 1);

        // R10: break at idle and across a character
        @(negedge clk);
        line_break = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R10 break at idle", int'(txd), 0);
        push(8'h5A);
        n = 0;
        repeat (100) begin
            @(negedge clk);
            n++;
        end
        chk(txd == 1'b0, "R10 break mid character", int'(txd), 0);
        chk(shifter_empty == 1'b0, "R10 character running under break", int'(shifter_empty), 0);
        while (!shifter_empty && n < 2000) begin
            @(negedge clk);
            n++;
            if (txd !== 1'b0) chk(1'b0, "R10 line low during break", int'(txd), 0);
        end
        chk(n >= 318 && n <= 326, "R10 timing kept under break", n, 322);
        @(negedge clk);
        line_break = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R10 line high after break", int'(txd), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule